// File: doc/BRIEF.md
# EEPROM Page-Write Buffer Controller

This block is a clocked, device-side model of the page-programming logic in a parallel byte-wide EEPROM. The chip-enable, write-strobe and output-enable lines are asynchronous and active low. They are brought into the clock domain through synchronizer chains. Every synchronized write-strobe pulse can deposit one byte into a temporary page buffer of 2^SLOT_W slots. A mask records which slots hold fresh data. The low address bits pick the slot, and the remaining upper bits name the page.

When the write strobe has stayed high for a programmable number of clocks after the most recent byte load, the block enters its internal program phase. It first erases each loaded cell to all ones and then writes the buffered value into that cell. Slots that were never loaded are left untouched. During this phase `busy_o` is high, further strobes are ignored and reads return zero. Outside programming, a read returns the contents of the behavioural byte array at the presented address, one register stage after the synchronized read enables.

All timing is counted in clock cycles. The byte-load window, the erase time and the write time are parameters.

Top module: `pgw_eeprom_ctrl`

## Requirements
- R1: A byte is loaded into slot `addr_i[SLOT_W-1:0]` on a synchronized rising edge of the write strobe only when the synchronized chip enable is low and the synchronized output enable is high. Loading the same slot again before programming keeps the later byte. A strobe pulse with chip enable high or output enable low loads nothing.
- R2: The page is `addr_i[ADDR_W-1:SLOT_W]`. It is captured on every synchronized falling edge of the write strobe taken with chip enable low. The capture at the last such falling edge before programming selects the page that is programmed.
- R3: Slots may be loaded in any order. Programming writes only the loaded slots of the selected page. Every other array location keeps its previous value.
- R4: Each strobe passes through a two-flop synchronizer. With at least one slot loaded, `busy_o` first reads high after the (T_BLC+3)th rising clock edge that follows the clock edge after which the raw write strobe rose for the last load. Only clocks in which the synchronized strobe is high advance this count.
- R5: A load sequence has no limit on its number of pulses or its total length, provided each gap of synchronized strobe-high between loads is shorter than T_BLC clocks. No programming starts during such a sequence.
- R6: The program phase erases each loaded cell to 8'hFF during T_ERASE clocks and then writes the buffered data during T_WRITE clocks. `busy_o` stays high for exactly T_ERASE+T_WRITE clocks, and the slot mask is empty when it falls.
- R7: While `busy_o` is high, write-strobe edges are ignored. They neither load bytes, change the page, nor cause a second program phase.
- R8: `data_o` is registered. One clock after synchronized chip enable and output enable are both low with `busy_o` low, it shows the array byte at `addr_i`. Otherwise, including any clock in which `busy_o` is high, it shows 8'h00.
- R9: After reset, `busy_o` is 0, `data_o` is 8'h00 and every array cell reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Asynchronous chip enable, active low |
| wr_strobe_n | input | 1 | Asynchronous write strobe, active low |
| rd_enable_n | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Byte address: slot in low SLOT_W bits, page above |
| data_i | input | DATA_W | Write data byte |
| data_o | output | DATA_W | Registered read data |
| busy_o | output | 1 | High while the program phase runs |

## Verification
The assertions assume that address and data stay steady for the three clocks a strobe edge needs to cross the synchronizer and be acted on. They also assume that no strobe edge arrives in the same clock in which programming ends, since such an edge could land on either side of the busy boundary. The stimulus holds every address and data pair for at least four clocks around each strobe edge. It keeps ordinary gaps between strobe pulses well inside T_BLC, and it places any pulse meant to be ignored fully inside the busy window, several clocks from both of its ends.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      PG_IDLE  = 2'd0,
      PG_ERASE = 2'd1,
      PG_WRITE = 2'd2
   } pg_state_e;

   localparam logic [7:0] PG_ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pgw_sync.sv
module pgw_sync #(
   parameter int           N       = 3,
   parameter int           STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pgw_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
   parameter int SLOT_W = 5,
   parameter int PAGE_W = 6,
   parameter int DATA_W = 8,
   localparam int SLOTS = 1 << SLOT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     page_ld,
   input  logic [PAGE_W-1:0]        page_in,
   input  logic                     load,
   input  logic [SLOT_W-1:0]        slot_in,
   input  logic [DATA_W-1:0]        data_in,
   input  logic                     clr,
   output logic [PAGE_W-1:0]        page_o,
   output logic [SLOTS-1:0]         valid_o,
   output logic [SLOTS*DATA_W-1:0]  bytes_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_o <= '0;
      else if (page_ld) page_o <= page_in;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o[s]                  <= 1'b0;
            bytes_o[s*DATA_W +: DATA_W] <= '0;
         end else if (clr) begin
            valid_o[s] <= 1'b0;
         end else if (load && (slot_in == SLOT_W'(s))) begin
            valid_o[s]                  <= 1'b1;
            bytes_o[s*DATA_W +: DATA_W] <= data_in;
         end
      end
   end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
   import pgw_pkg::*;
#(
   parameter int T_BLC   = 16,
   parameter int T_ERASE = 8,
   parameter int T_WRITE = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we_hi,
   input  logic load,
   input  logic any_valid,
   output logic busy_o,
   output logic erase_go,
   output logic write_go
);
   localparam int MAX_AB = (T_BLC > T_ERASE) ? T_BLC : T_ERASE;
   localparam int MAXT   = (MAX_AB > T_WRITE) ? MAX_AB : T_WRITE;
   localparam int CW     = $clog2(MAXT + 1);

   pg_state_e      st;
   logic [CW-1:0]  cnt;

   assign busy_o   = (st != PG_IDLE);
   assign erase_go = (st == PG_ERASE) && (cnt == CW'(T_ERASE - 1));
   assign write_go = (st == PG_WRITE) && (cnt == CW'(T_WRITE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PG_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            PG_IDLE: begin
               if (load) begin
                  cnt <= '0;
               end else if (any_valid && we_hi) begin
                  if (cnt == CW'(T_BLC - 1)) begin
                     st  <= PG_ERASE;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PG_ERASE: begin
               if (erase_go) begin
                  st  <= PG_WRITE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PG_WRITE: begin
               if (write_go) begin
                  st  <= PG_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               st  <= PG_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pgw_array.sv
module pgw_array
   import pgw_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int SLOT_W = 5,
   parameter int DATA_W = 8,
   localparam int SLOTS = 1 << SLOT_W,
   localparam int PAGE_W = ADDR_W - SLOT_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PAGE_W-1:0]       page,
   input  logic [SLOTS-1:0]        valid,
   input  logic [SLOTS*DATA_W-1:0] bytes,
   input  logic                    erase_go,
   input  logic                    write_go,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data
);
   localparam logic [DATA_W-1:0] ERASED = DATA_W'(PG_ERASED_BYTE);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
         rd_data <= '0;
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (valid[s]) begin
               if (erase_go)      mem[{page, SLOT_W'(s)}] <= ERASED;
               else if (write_go) mem[{page, SLOT_W'(s)}] <= bytes[s*DATA_W +: DATA_W];
            end
         end
         rd_data <= rd_en ? mem[rd_addr] : '0;
      end
   end
endmodule

// File: rtl/pgw_eeprom_ctrl.sv
module pgw_eeprom_ctrl #(
   parameter int ADDR_W      = 11,
   parameter int SLOT_W      = 5,
   parameter int DATA_W      = 8,
   parameter int T_BLC       = 16,
   parameter int T_ERASE     = 8,
   parameter int T_WRITE     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel_n,
   input  logic              wr_strobe_n,
   input  logic              rd_enable_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              busy_o
);
   localparam int PAGE_W = ADDR_W - SLOT_W;
   localparam int SLOTS  = 1 << SLOT_W;

   if (ADDR_W <= SLOT_W) begin : g_bad_addr
      $error("pgw_eeprom_ctrl: ADDR_W must exceed SLOT_W");
   end
   if (T_BLC < 1 || T_ERASE < 1 || T_WRITE < 1) begin : g_bad_time
      $error("pgw_eeprom_ctrl: timing parameters must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pgw_eeprom_ctrl: DATA_W must be positive");
   end

   logic [2:0] strb_s;
   logic       ce_s, we_s, oe_s, we_d;
   logic       we_rise, we_fall, load, page_ld, rd_en;
   logic       erase_go, write_go;
   logic [PAGE_W-1:0]       page_q;
   logic [SLOTS-1:0]        slot_valid;
   logic [SLOTS*DATA_W-1:0] slot_bytes;

   pgw_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({chip_sel_n, wr_strobe_n, rd_enable_n}),
      .q_o   (strb_s)
   );
   assign ce_s = strb_s[2];
   assign we_s = strb_s[1];
   assign oe_s = strb_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_d <= 1'b1;
      else        we_d <= we_s;
   end

   assign we_rise = we_s & ~we_d;
   assign we_fall = ~we_s & we_d;
   assign load    = we_rise & ~ce_s & oe_s & ~busy_o;
   assign page_ld = we_fall & ~ce_s & ~busy_o;
   assign rd_en   = ~ce_s & ~oe_s & ~busy_o;

   pgw_page_buf #(.SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .page_ld (page_ld),
      .page_in (addr_i[ADDR_W-1:SLOT_W]),
      .load    (load),
      .slot_in (addr_i[SLOT_W-1:0]),
      .data_in (data_i),
      .clr     (write_go),
      .page_o  (page_q),
      .valid_o (slot_valid),
      .bytes_o (slot_bytes)
   );

   pgw_seq #(.T_BLC(T_BLC), .T_ERASE(T_ERASE), .T_WRITE(T_WRITE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_hi     (we_s),
      .load      (load),
      .any_valid (|slot_valid),
      .busy_o    (busy_o),
      .erase_go  (erase_go),
      .write_go  (write_go)
   );

   pgw_array #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .page     (page_q),
      .valid    (slot_valid),
      .bytes    (slot_bytes),
      .erase_go (erase_go),
      .write_go (write_go),
      .rd_en    (rd_en),
      .rd_addr  (addr_i),
      .rd_data  (data_o)
   );
endmodule

// File: rtl/pgw_eeprom_ctrl_chk.sv
module pgw_eeprom_ctrl_chk #(
   parameter int T_ERASE = 8,
   parameter int T_WRITE = 12,
   parameter int SLOTS   = 32,
   parameter int DATA_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic [DATA_W-1:0] data_o,
   input logic [SLOTS-1:0]  valid,
   input logic              erase_go,
   input logic              write_go,
   input logic              we_s
);
   logic [15:0] run;
   logic        erased;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= '0;
         erased <= 1'b0;
      end else begin
         run <= busy_o ? run + 16'd1 : 16'd0;
         if (erase_go)      erased <= 1'b1;
         else if (write_go) erased <= 1'b0;
      end
   end

   // R6: program phase length
   a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> run == 16'(T_ERASE + T_WRITE));

   // R6: slot mask empty once programming ends
   a_r6_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> valid == '0);

   // R6: erase precedes write
   a_r6_erase_first: assert property (@(posedge clk) disable iff (!rst_n)
      write_go |-> erased);

   // R7: buffer frozen while busy
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (!busy_o || $stable(valid)));

   // R4: programming starts only with loaded slots and strobe high
   a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ((|valid) && $past(we_s)));

   // R8: reads blocked while busy
   a_r8_rd_block: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> data_o == '0);
endmodule

bind pgw_eeprom_ctrl pgw_eeprom_ctrl_chk #(
   .T_ERASE (T_ERASE),
   .T_WRITE (T_WRITE),
   .SLOTS   (1 << SLOT_W),
   .DATA_W  (DATA_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_o   (busy_o),
   .data_o   (data_o),
   .valid    (slot_valid),
   .erase_go (erase_go),
   .write_go (write_go),
   .we_s     (we_s)
);

// File: tb/pgw_eeprom_ctrl_tb_top.sv
module pgw_eeprom_ctrl_tb_top;
   localparam int CLK_P   = 10;
   localparam int ADDR_W  = 11;
   localparam int SLOT_W  = 5;
   localparam int DATA_W  = 8;
   localparam int T_BLC   = 16;
   localparam int T_ERASE = 8;
   localparam int T_WRITE = 12;
   localparam int DEPTH   = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1;
   logic              we_n = 1'b1;
   logic              oe_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] din = '0;
   logic [DATA_W-1:0] data_o;
   logic              busy_o;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   logic [7:0] mdl_mem [DEPTH];
   int  pend_data [int];
   int  pend_page = 0;
   bit  have_pend = 1'b0;
   int  st = 0;

   pgw_eeprom_ctrl #(
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W),
      .T_BLC(T_BLC), .T_ERASE(T_ERASE), .T_WRITE(T_WRITE), .SYNC_STAGES(2)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .chip_sel_n  (ce_n),
      .wr_strobe_n (we_n),
      .rd_enable_n (oe_n),
      .addr_i      (addr),
      .data_i      (din),
      .data_o      (data_o),
      .busy_o      (busy_o)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model: busy window and commit, compared every clock (R4 R6)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_busy;
         exp_busy = have_pend && (cyc >= st) && (cyc < st + T_ERASE + T_WRITE);
         chk("R4 R6 busy timing", int'(busy_o), int'(exp_busy));
         if (have_pend && cyc >= st + T_ERASE + T_WRITE) begin
            foreach (pend_data[k]) mdl_mem[pend_page*32 + k] = 8'(pend_data[k]);
            pend_data.delete();
            have_pend = 1'b0;
         end
      end
   end

   task automatic pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input int hi, input bit acc);
      @(negedge clk);
      addr = a; din = d; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      if (acc) begin
         pend_page = int'(a >> SLOT_W);
         pend_data[int'(a[SLOT_W-1:0])] = int'(d);
         have_pend = 1'b1;
         st = cyc + 3 + T_BLC;
      end
      repeat (hi) @(negedge clk);
   endtask

   task automatic rd_exp(input logic [ADDR_W-1:0] a, input int exp, input string req);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = a;
      repeat (5) @(negedge clk);
      chk(req, int'(data_o), exp);
      oe_n = 1'b1;
   endtask

   task automatic rd(input int pg, input int sl, input string req);
      rd_exp(ADDR_W'(pg*32 + sl), int'(mdl_mem[pg*32 + sl]), req);
   endtask

   task automatic wait_done();
      while (have_pend) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R5 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      chk("R9 busy after reset", int'(busy_o), 0);
      chk("R9 data_o after reset", int'(data_o), 0);
      rd(0, 0, "R9 erased cell low");
      rd(63, 31, "R9 erased cell high");

      // R1 R3: out-of-order loads, slot 3 written twice, read blocked while busy (R8)
      ce_n = 1'b0; oe_n = 1'b1;
      pulse(11'(2*32 + 3),  8'h11, 5, 1'b1);
      pulse(11'(2*32 + 0),  8'h22, 5, 1'b1);
      pulse(11'(2*32 + 31), 8'h33, 5, 1'b1);
      pulse(11'(2*32 + 7),  8'h44, 5, 1'b1);
      pulse(11'(2*32 + 3),  8'h55, 5, 1'b1);
      while (!busy_o) @(negedge clk);
      rd_exp(11'(2*32 + 3), 0, "R8 read while busy");
      wait_done();
      for (int s = 0; s < 32; s++) rd(2, s, "R3 page 2 contents");
      chk("R1 later data wins", int'(mdl_mem[2*32+3]), 8'h55);
      rd(1, 31, "R3 neighbour below");
      rd(3, 0, "R3 neighbour above");

      // R2: page from last falling edge
      pulse(11'(5*32 + 1), 8'hA1, 5, 1'b1);
      pulse(11'(5*32 + 2), 8'hA2, 5, 1'b1);
      pulse(11'(9*32 + 4), 8'hA4, 5, 1'b1);
      wait_done();
      rd_exp(11'(9*32 + 1), 8'hA1, "R2 last page slot1");
      rd_exp(11'(9*32 + 2), 8'hA2, "R2 last page slot2");
      rd_exp(11'(9*32 + 4), 8'hA4, "R2 last page slot4");
      rd_exp(11'(5*32 + 1), 8'hFF, "R2 earlier page untouched");
      rd_exp(11'(5*32 + 2), 8'hFF, "R2 earlier page untouched");

      // R3: partial reprogram keeps the rest
      pulse(11'(2*32 + 0), 8'h99, 5, 1'b1);
      wait_done();
      rd_exp(11'(2*32 + 0),  8'h99, "R3 reloaded slot");
      rd_exp(11'(2*32 + 3),  8'h55, "R3 kept slot 3");
      rd_exp(11'(2*32 + 31), 8'h33, "R3 kept slot 31");
      rd_exp(11'(2*32 + 7),  8'h44, "R3 kept slot 7");
      rd_exp(11'(2*32 + 10), 8'hFF, "R3 kept unloaded slot");

      // R1: pulses with OE low or CE high load nothing
      oe_n = 1'b0;
      pulse(11'(7*32 + 0), 8'h12, 5, 1'b0);
      oe_n = 1'b1;
      ce_n = 1'b1;
      pulse(11'(7*32 + 1), 8'h13, 5, 1'b0);
      ce_n = 1'b0;
      repeat (40) @(negedge clk);
      rd_exp(11'(7*32 + 0), 8'hFF, "R1 OE low ignored");
      rd_exp(11'(7*32 + 1), 8'hFF, "R1 CE high ignored");

      // R7: pulse during busy ignored
      pulse(11'(11*32 + 0), 8'h5A, 5, 1'b1);
      while (!busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      pulse(11'(12*32 + 1), 8'h77, 5, 1'b0);
      wait_done();
      repeat (40) @(negedge clk);
      rd_exp(11'(11*32 + 0), 8'h5A, "R7 programmed slot");
      rd_exp(11'(11*32 + 1), 8'hFF, "R7 busy load ignored");
      rd_exp(11'(12*32 + 1), 8'hFF, "R7 busy page ignored");

      // R5: long sequence, gaps just under the window
      for (int i = 0; i < 40; i++)
         pulse(11'(20*32 + (i % 8)), 8'(i), T_BLC - 3, 1'b1);
      wait_done();
      for (int s = 0; s < 8; s++)
         rd_exp(11'(20*32 + s), 32 + s, "R5 long sequence result");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule